// File: doc/BRIEF.md
# Host Port Scanner

This block is the arbitration core of a keyboard switch that shares one keyboard among three host computers. Each host port has an open-collector clock line and an open-collector data line. The block steps through the hosts one slot at a time, in a fixed ring. It keeps a sticky mask of the hosts it has seen with both lines idle, and it lets the serial bit engines work only on hosts in that mask.

In the slot of a connected host, the block first pulses a strobe that tells the host-side receive engine to service the selected port. It then waits for that engine's done pulse. After that it pulses a keyboard-side strobe and waits again. A free-running timeout counter restarts at the start of every slot. Its expiry flag lets the engines give up on a stuck port, and it also releases the scanner from either wait.

A separate request input moves the current-host pointer, which drives the three mouse-enable outputs. A request is honoured only when it names exactly one host and that host is connected.

Top module: `host_port_scanner`

## Requirements
- R1: `scan_sel_o` always has exactly one bit set: bit 0 is host A, bit 1 is host B, bit 2 is host C. After reset it is `001`. Each time the slot ends it advances A→B→C→A.
- R2: `connected_o` is `000` after reset. A host's bit is set when its clock and data inputs are both high in the cycle that starts its slot. The bit is visible in the next cycle.
- R3: A connected bit is never cleared by the scanner. A low line in a later slot leaves the bit unchanged.
- R4: The slot of an unconnected host lasts one cycle and raises no strobe. With every line low, `scan_sel_o` advances on every clock.
- R5: For a connected host, `host_svc_o` is a one-cycle pulse in the cycle after the slot starts. `kbd_svc_o` is a one-cycle pulse in the cycle after `host_done_i` is sampled high during the host wait. The cycle after `kbd_done_i` is sampled high during the keyboard wait starts the next slot, with `scan_sel_o` advanced. No strobe appears while a wait is pending.
- R6: The timeout counter is 16 bits wide, runs at one count per clock, and restarts at every slot start. If no done arrives, `wdog_ovf_o` rises 65536 cycles after the `host_svc_o` pulse. It stays high until the next slot start clears it, and it is low in the cycle after that start.
- R7: While `wdog_ovf_o` is high, the host wait ends and `kbd_svc_o` follows one cycle after the flag rises. The keyboard wait also ends at once, so the next slot's `scan_sel_o` appears two cycles after `kbd_svc_o`.
- R8: After reset `cur_host_o` and `mouse_en_o` are both `001` (host A). `mouse_en_o` always equals the one-hot `cur_host_o`.
- R9: `switch_req_i` is accepted only when it has exactly one bit set and that host's connected bit is set. The new host appears on `cur_host_o` one cycle later. Any other request value leaves `cur_host_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_clk_i | input | 3 | Sampled clock line of each host port (1 = released) |
| host_dat_i | input | 3 | Sampled data line of each host port (1 = released) |
| host_done_i | input | 1 | Host-side engine finished its service |
| kbd_done_i | input | 1 | Keyboard-side engine finished its service |
| switch_req_i | input | 3 | Request to change the current host, one-hot |
| scan_sel_o | output | 3 | One-hot host being visited |
| host_svc_o | output | 1 | One-cycle strobe: service the host receive path |
| kbd_svc_o | output | 1 | One-cycle strobe: service the keyboard path |
| connected_o | output | 3 | Sticky connected mask |
| cur_host_o | output | 3 | One-hot current host |
| mouse_en_o | output | 3 | Mouse enables, one per host |
| wdog_ovf_o | output | 1 | Timeout expired in the current slot |

## Verification
Inputs change on the falling edge and outputs are read on the next falling edge, so a result registered at the edge between them is checked one cycle after its cause. The service strobe and the connected bit are checked in the cycle after the slot start, `kbd_svc_o` one cycle after the done pulse, the advanced selection one cycle after `kbd_done_i`, and a new current host one cycle after the request. For the timeout, the bench counts cycles from the host strobe and expects the flag at exactly 65536. It then expects `kbd_svc_o` one cycle later, the next selection two cycles after the strobe, and the flag low one cycle after that. In the random rounds the line pattern is held steady, and the bench predicts which host is serviced next from its own connected mask and ring order.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  localparam int unsigned HOSTS = 3;
  typedef enum logic [2:0] {
    ST_SLOT,
    ST_HOST_GO,
    ST_HOST_WAIT,
    ST_KBD_GO,
    ST_KBD_WAIT
  } scan_state_e;
endpackage

// File: rtl/hsw_scan_ring.sv
module hsw_scan_ring #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [N-1:0] sel_o
);
  localparam logic [N-1:0] FIRST = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] sel_q, rot;

  for (genvar i = 0; i < N; i++) begin : g_rot
    localparam int unsigned PREV = (i == 0) ? N - 1 : i - 1;
    assign rot[i] = sel_q[PREV];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= FIRST;
    else if (step_i) sel_q <= rot;
  end

  assign sel_o = sel_q;

  assert_sel_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sel_q) == 1);
  assert_step_moves_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> sel_q != $past(sel_q));
  assert_hold_still_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(sel_q));
endmodule

// File: rtl/hsw_link_track.sv
module hsw_link_track #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sample_i,
  input  logic [N-1:0] sel_i,
  input  logic [N-1:0] line_clk_i,
  input  logic [N-1:0] line_dat_i,
  output logic [N-1:0] conn_o,
  output logic         grant_o
);
  logic [N-1:0] conn_q, idle, mark;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign idle[i] = line_clk_i[i] & line_dat_i[i];
    assign mark[i] = sample_i & sel_i[i] & idle[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      conn_q[i] <= 1'b0;
      else if (mark[i]) conn_q[i] <= 1'b1;
    end

    assert_conn_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      conn_q[i] |=> conn_q[i]);
    assert_conn_needs_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(conn_q[i]) |-> $past(sample_i && sel_i[i] && line_clk_i[i] && line_dat_i[i]));
  end

  // decision sees the bit set in this very slot
  assign grant_o = |(sel_i & (conn_q | idle));
  assign conn_o  = conn_q;
endmodule

// File: rtl/hsw_wdog.sv
module hsw_wdog #(
  parameter int unsigned W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic ovf_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic         ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == TOP) ovf_q <= 1'b1;
    end
  end

  assign ovf_o = ovf_q;

  assert_clear_drops_ovf_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !ovf_q);
  assert_ovf_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !clear_i) |=> ovf_q);
endmodule

// File: rtl/hsw_host_select.sv
module hsw_host_select #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] conn_i,
  output logic [N-1:0] cur_o
);
  localparam logic [N-1:0] FIRST = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] cur_q;
  logic         single, linked;

  assign single = (req_i != '0) && ((req_i & (req_i - 1'b1)) == '0);
  assign linked = (req_i & ~conn_i) == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cur_q <= FIRST;
    else if (single && linked) cur_q <= req_i;
  end

  assign cur_o = cur_q;

  assert_cur_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cur_q) == 1);
  assert_cur_needs_link_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cur_q) |-> (|($past(conn_i) & cur_q)) && $countones($past(req_i)) == 1);
endmodule

// File: rtl/host_port_scanner.sv
module host_port_scanner
  import hsw_pkg::*;
#(
  parameter int unsigned NH   = HOSTS,
  parameter int unsigned WD_W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NH-1:0] host_clk_i,
  input  logic [NH-1:0] host_dat_i,
  input  logic          host_done_i,
  input  logic          kbd_done_i,
  input  logic [NH-1:0] switch_req_i,
  output logic [NH-1:0] scan_sel_o,
  output logic          host_svc_o,
  output logic          kbd_svc_o,
  output logic [NH-1:0] connected_o,
  output logic [NH-1:0] cur_host_o,
  output logic [NH-1:0] mouse_en_o,
  output logic          wdog_ovf_o
);
  scan_state_e  state_q, state_d;
  logic         in_slot, grant, step, ovf;
  logic [NH-1:0] sel, conn, cur;

  assign in_slot = (state_q == ST_SLOT);

  always_comb begin
    state_d = state_q;
    step    = 1'b0;
    unique case (state_q)
      ST_SLOT: begin
        if (grant) state_d = ST_HOST_GO;
        else       step    = 1'b1;
      end
      ST_HOST_GO:   state_d = ST_HOST_WAIT;
      ST_HOST_WAIT: if (host_done_i || ovf) state_d = ST_KBD_GO;
      ST_KBD_GO:    state_d = ST_KBD_WAIT;
      ST_KBD_WAIT: begin
        if (kbd_done_i || ovf) begin
          state_d = ST_SLOT;
          step    = 1'b1;
        end
      end
      default: state_d = ST_SLOT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_SLOT;
    else         state_q <= state_d;
  end

  hsw_scan_ring #(.N(NH)) u_ring (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(step),
    .sel_o (sel)
  );

  hsw_link_track #(.N(NH)) u_link (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sample_i  (in_slot),
    .sel_i     (sel),
    .line_clk_i(host_clk_i),
    .line_dat_i(host_dat_i),
    .conn_o    (conn),
    .grant_o   (grant)
  );

  hsw_wdog #(.W(WD_W)) u_wdog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(in_slot),
    .ovf_o  (ovf)
  );

  hsw_host_select #(.N(NH)) u_sel (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (switch_req_i),
    .conn_i(conn),
    .cur_o (cur)
  );

  assign scan_sel_o  = sel;
  assign host_svc_o  = (state_q == ST_HOST_GO);
  assign kbd_svc_o   = (state_q == ST_KBD_GO);
  assign connected_o = conn;
  assign cur_host_o  = cur;
  assign mouse_en_o  = cur;
  assign wdog_ovf_o  = ovf;

  assert_svc_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_svc_o && kbd_svc_o));
  assert_host_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_svc_o |=> !host_svc_o && !kbd_svc_o);
  assert_kbd_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kbd_svc_o |=> !kbd_svc_o && $stable(scan_sel_o));
  assert_svc_connected_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_svc_o |-> |(scan_sel_o & connected_o));
  assert_kbd_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kbd_svc_o |-> $past(host_done_i || wdog_ovf_o));
  assert_mouse_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mouse_en_o == cur_host_o);
endmodule

// File: tb/host_port_scanner_test.sv
module host_port_scanner_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] host_clk = '0, host_dat = '0, switch_req = '0;
  logic       host_done = 1'b0, kbd_done = 1'b0;
  logic [2:0] scan_sel, connected, cur_host, mouse_en;
  logic       host_svc, kbd_svc, wdog_ovf;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  logic [2:0] conn_exp;

  always #10 clk = ~clk;

  host_port_scanner uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .host_clk_i  (host_clk),
    .host_dat_i  (host_dat),
    .host_done_i (host_done),
    .kbd_done_i  (kbd_done),
    .switch_req_i(switch_req),
    .scan_sel_o  (scan_sel),
    .host_svc_o  (host_svc),
    .kbd_svc_o   (kbd_svc),
    .connected_o (connected),
    .cur_host_o  (cur_host),
    .mouse_en_o  (mouse_en),
    .wdog_ovf_o  (wdog_ovf)
  );

  function automatic logic [2:0] nxt(input logic [2:0] s);
    return {s[1:0], s[2]};
  endfunction

  function automatic logic [2:0] first_in(input logic [2:0] pos, input logic [2:0] mask);
    logic [2:0] p = pos;
    for (int i = 0; i < 3; i++) begin
      if ((p & mask) != 0) return p;
      p = nxt(p);
    end
    return 3'b000;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_svc(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (host_svc) begin
        seen = 1'b1;
        break;
      end
    end
    chk(seen, "R5", "host strobe seen", int'(seen), 1);
  endtask

  // called at the negedge where host_svc is high
  task automatic serve(input int d1, input int d2);
    logic [2:0] s = scan_sel;
    for (int i = 0; i < d1; i++) begin
      @(negedge clk);
      chk(!host_svc && !kbd_svc, "R5", "no strobe in host wait",
          {host_svc, kbd_svc}, 0);
    end
    host_done = 1'b1;
    @(negedge clk);
    host_done = 1'b0;
    chk(kbd_svc, "R5", "kbd strobe after host done", int'(kbd_svc), 1);
    chk(scan_sel == s, "R5", "sel held during slot", scan_sel, s);
    for (int i = 0; i < d2; i++) begin
      @(negedge clk);
      chk(!host_svc && !kbd_svc, "R5", "no strobe in kbd wait",
          {host_svc, kbd_svc}, 0);
    end
    kbd_done = 1'b1;
    @(negedge clk);
    kbd_done = 1'b0;
    chk(scan_sel == nxt(s), "R5", "sel advances after kbd done", scan_sel, nxt(s));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [2:0] exp_sel, pos, h, m, x, y;
    bit seen;
    int k;
    void'($urandom(32'h1a2b3c4d));

    repeat (3) @(negedge clk);
    chk(scan_sel == 3'b001, "R1", "reset sel", scan_sel, 1);
    chk(connected == 3'b000, "R2", "reset mask", connected, 0);
    chk(cur_host == 3'b001 && mouse_en == 3'b001, "R8", "reset current host",
        {cur_host, mouse_en}, 6'o11);
    chk(!host_svc && !kbd_svc && !wdog_ovf, "R6", "reset strobes/flag",
        {host_svc, kbd_svc, wdog_ovf}, 0);
    rst_ni = 1'b1;

    // all lines low: one cycle per slot, no service
    exp_sel = 3'b001;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      exp_sel = nxt(exp_sel);
      chk(scan_sel == exp_sel, "R4", "skip one slot per cycle", scan_sel, exp_sel);
      chk(!host_svc && connected == 0, "R4", "no strobe, empty mask",
          {host_svc, connected}, 0);
    end
    switch_req = 3'b010;
    @(negedge clk);
    switch_req = 3'b000;
    chk(cur_host == 3'b001, "R9", "request to unconnected host ignored", cur_host, 1);

    // host B goes idle
    host_clk = 3'b010;
    host_dat = 3'b010;
    wait_svc(seen);
    chk(scan_sel == 3'b010, "R2", "B serviced", scan_sel, 2);
    chk(connected == 3'b010, "R2", "B marked", connected, 2);
    serve(1, 1);
    conn_exp = 3'b010;

    // B lines drop: stays connected
    host_clk = 3'b000;
    host_dat = 3'b010;
    wait_svc(seen);
    chk(scan_sel == 3'b010 && connected == 3'b010, "R3", "mask kept with low line",
        {scan_sel, connected}, 6'o22);
    serve(2, 3);

    // random rounds; host C never sees both lines idle
    for (int r = 0; r < 6; r++) begin
      m = 3'($urandom) & 3'b011;
      x = 3'($urandom);
      y = 3'($urandom) & ~x;
      host_clk = m | x;
      host_dat = m | y;
      conn_exp = conn_exp | m;
      pos = scan_sel;
      for (int s = 0; s < 4; s++) begin
        wait_svc(seen);
        h = first_in(pos, conn_exp);
        chk(scan_sel == h, "R1", "round-robin service order", scan_sel, h);
        chk(!wdog_ovf, "R6", "no timeout in normal service", int'(wdog_ovf), 0);
        serve(1 + int'($urandom % 4), 1 + int'($urandom % 4));
        pos = nxt(h);
      end
      chk(connected == conn_exp, "R2", "mask after round", connected, conn_exp);
    end

    // timeout: no done; switch requests meanwhile
    wait_svc(seen);
    pos = scan_sel;
    fork
      begin
        k = 0;
        while (!wdog_ovf && k < 70000) begin
          @(negedge clk);
          k++;
        end
      end
      begin
        switch_req = 3'b100;
        @(negedge clk);
        chk(cur_host == 3'b001, "R9", "unconnected C refused", cur_host, 1);
        switch_req = 3'b110;
        @(negedge clk);
        chk(cur_host == 3'b001, "R9", "two-bit request refused", cur_host, 1);
        switch_req = 3'b010;
        @(negedge clk);
        chk(cur_host == 3'b010 && mouse_en == 3'b010, "R8", "switch to B",
            {cur_host, mouse_en}, 6'o22);
        switch_req = 3'b000;
        @(negedge clk);
        @(negedge clk);
        chk(cur_host == 3'b010, "R9", "zero request holds", cur_host, 2);
      end
    join
    chk(k == 65536, "R6", "timeout distance from strobe", k, 65536);
    @(negedge clk);
    chk(kbd_svc, "R7", "kbd strobe after timeout", int'(kbd_svc), 1);
    @(negedge clk);
    @(negedge clk);
    chk(scan_sel == nxt(pos), "R7", "slot ends on timeout", scan_sel, nxt(pos));
    @(negedge clk);
    chk(!wdog_ovf, "R6", "flag cleared by slot start", int'(wdog_ovf), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule